// File: doc/BRIEF.md
# Standby Clock Gating Controller

This block puts a small processor system into one of two low-power standby depths and brings it back out. A halt request stops only the clocks of the processor, its zero-wait local RAM and a group of peripherals that are allowed to stop on their own. Every other peripheral and the interrupt controller keep running. A sleep request stops every gated clock domain, the interrupt controller included, after a bounded stop delay counted in source-clock cycles. Only the free-running source clock domain, which this block itself runs on, stays active.

Each depth has its own set of wake sources. Asynchronous wake inputs pass through a two-flop synchronizer. In sleep the interrupt controller has no clock, so the raw enabled interrupt lines are used directly as the wake condition, and a capture strobe tells the interrupt controller to latch its pending flags once its clock is back. On every wake, the block tells the processor either to take a trap or, when the interrupt was masked at processor level, to resume with no handler. The block also holds the clock-source selection and accepts a change to it only while the system is asleep.

Clock enables are held in latches that are open only while the source clock is low, so the gated clock outputs never carry a shortened pulse.

Top module: `standby_clkctl`

## Requirements
- R1: While reset is low and just after it is released, the block is running: all five clock enables are 1, `wake_en` is 0, `src_sel` is 0, and `switch_ok`, `wake_trap`, `wake_nohandler` and `itc_cap` are 0.
- R2: A `halt_req` that is sampled high while running clears the enables of the CPU, the RAM and the auto-stop group, starting in the low phase after the sampling edge. The peripheral and interrupt-controller enables stay 1.
- R3: A `sleep_req` that is sampled high while running keeps all enables at 1 through the low phase after the 7th rising edge, counting the sampling edge as the 1st. It clears all five enables in the low phase after the 8th edge (STOP_CYC = 8). If `sleep_req` and `halt_req` are both high, sleep is taken.
- R4: Halt is left when NMI falls, when any `irq_lines` bit is high, when `rtc_irq` is high, or when `dbg_break` is high. The enables return in the low phase after the 3rd rising edge after the input changes, and they are still off after the 2nd.
- R5: Sleep is left when NMI falls or when `rtc_irq` is high. `irq_lines` wakes it only when `wake_en` is 1, and `dbg_break` does not wake it. The latency is the same as in R4.
- R6: On a wake, `wake_trap` pulses for one cycle when the cause includes an NMI fall, or when it is an interrupt with `int_mask` = 0. `wake_nohandler` pulses instead when it is only an interrupt with `int_mask` = 1. A wake caused only by `dbg_break` pulses neither. Both pulses rise at the edge that restores the enables.
- R7: One cycle after a wake from sleep caused by `irq_lines` or `rtc_irq`, `itc_cap` pulses for one cycle, while the interrupt-controller clock is already running. It never pulses after a wake from halt.
- R8: `switch_ok` is 1 exactly while the system is asleep. A write on `src_wr` copies the 2-bit `src_nxt` into `src_sel` only while asleep and is ignored in any other state.
- R9: `halt_req` and `sleep_req` are ignored outside the running state. NMI wakes only on a falling edge, so an NMI that is held low does not wake a later halt.
- R10: The enables change only while `clk` is low, and each gated clock is `clk` ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Request to enter halt (from CPU) |
| sleep_req | input | 1 | Request to enter sleep (from CPU) |
| nmi_n | input | 1 | Active-low non-maskable interrupt, asynchronous |
| irq_lines | input | NIRQ | Enabled interrupt request lines, asynchronous |
| rtc_irq | input | 1 | Real-time clock interrupt, asynchronous |
| dbg_break | input | 1 | Debugger forced break, asynchronous |
| int_mask | input | 1 | Processor-level interrupt disable |
| wen_wr | input | 1 | Write strobe for the external-interrupt wake enable |
| wen_din | input | 1 | Value written to the wake enable |
| src_wr | input | 1 | Clock-source select write strobe |
| src_nxt | input | 2 | Requested clock-source select code |
| cpu_ce | output | 1 | CPU clock enable |
| ram_ce | output | 1 | Zero-wait local RAM clock enable |
| auto_ce | output | 1 | Auto-stop peripheral group clock enable |
| per_ce | output | 1 | General peripheral clock enable |
| itc_ce | output | 1 | Interrupt controller clock enable |
| cpu_gclk | output | 1 | Gated CPU clock |
| ram_gclk | output | 1 | Gated RAM clock |
| auto_gclk | output | 1 | Gated auto-stop peripheral clock |
| per_gclk | output | 1 | Gated peripheral clock |
| itc_gclk | output | 1 | Gated interrupt controller clock |
| switch_ok | output | 1 | Clock-source switch permitted (asleep) |
| src_sel | output | 2 | Current clock-source select code |
| wake_en | output | 1 | External-interrupt wake enable |
| wake_trap | output | 1 | One-cycle pulse: take trap on wake |
| wake_nohandler | output | 1 | One-cycle pulse: resume without handler |
| itc_cap | output | 1 | One-cycle pulse: interrupt controller may capture pending flags |

## Verification
The assertions assume that `int_mask`, the request inputs and the write strobes are synchronous to `clk` and settle well away from the rising edge. They also assume that the asynchronous wake lines stay at each level long enough for the two-flop synchronizer to see it. The bench drives every input one nanosecond after a falling edge. It holds each wake source for at least three rising edges and releases it before the next scenario, so the synchronizer always settles. Reset is applied only in the low phase, which keeps the enable latches from opening in mid-pulse.

// File: rtl/standby_clkctl.sv
module standby_clkctl #(
  parameter int NIRQ     = 4,
  parameter int STOP_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic            sleep_req,
  input  logic            nmi_n,
  input  logic [NIRQ-1:0] irq_lines,
  input  logic            rtc_irq,
  input  logic            dbg_break,
  input  logic            int_mask,
  input  logic            wen_wr,
  input  logic            wen_din,
  input  logic            src_wr,
  input  logic [1:0]      src_nxt,
  output logic            cpu_ce,
  output logic            ram_ce,
  output logic            auto_ce,
  output logic            per_ce,
  output logic            itc_ce,
  output logic            cpu_gclk,
  output logic            ram_gclk,
  output logic            auto_gclk,
  output logic            per_gclk,
  output logic            itc_gclk,
  output logic            switch_ok,
  output logic [1:0]      src_sel,
  output logic            wake_en,
  output logic            wake_trap,
  output logic            wake_nohandler,
  output logic            itc_cap
);

  localparam int SW = NIRQ + 3;
  localparam int CW = (STOP_CYC > 2) ? $clog2(STOP_CYC) : 1;
  localparam logic [SW-1:0] SYNC_RST = SW'(1) << NIRQ;
  localparam logic [CW-1:0] CNT_LOAD = CW'(STOP_CYC - 2);

  typedef enum logic [1:0] {S_RUN, S_HALT, S_PEND, S_SLEEP} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [SW-1:0] sy1, sy2;
  logic          nmi_q;
  logic          cap_pend;
  logic [4:0]    en_d, ce;

  wire nmi_fall = nmi_q & ~sy2[NIRQ];
  wire irq_s    = |sy2[NIRQ-1:0];
  wire rtc_s    = sy2[NIRQ+1];
  wire dbg_s    = sy2[NIRQ+2];
  wire h_irq    = irq_s | rtc_s;
  wire s_irq    = (irq_s & wake_en) | rtc_s;
  wire h_wake   = nmi_fall | h_irq | dbg_s;
  wire s_wake   = nmi_fall | s_irq;
  wire h_trap   = nmi_fall | (h_irq & ~int_mask);
  wire h_nh     = ~nmi_fall & h_irq & int_mask;
  wire s_trap   = nmi_fall | (s_irq & ~int_mask);
  wire s_nh     = ~nmi_fall & s_irq & int_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_RUN;
      cnt            <= '0;
      sy1            <= SYNC_RST;
      sy2            <= SYNC_RST;
      nmi_q          <= 1'b1;
      cap_pend       <= 1'b0;
      itc_cap        <= 1'b0;
      wake_trap      <= 1'b0;
      wake_nohandler <= 1'b0;
      wake_en        <= 1'b0;
      src_sel        <= 2'd0;
    end else begin
      sy1            <= {dbg_break, rtc_irq, nmi_n, irq_lines};
      sy2            <= sy1;
      nmi_q          <= sy2[NIRQ];
      wake_trap      <= 1'b0;
      wake_nohandler <= 1'b0;
      itc_cap        <= cap_pend;
      cap_pend       <= 1'b0;
      if (wen_wr) wake_en <= wen_din;
      if (src_wr && st == S_SLEEP) src_sel <= src_nxt;
      case (st)
        S_RUN: begin
          if (sleep_req) begin
            st  <= S_PEND;
            cnt <= CNT_LOAD;
          end else if (halt_req) begin
            st <= S_HALT;
          end
        end
        S_HALT: begin
          if (h_wake) begin
            st             <= S_RUN;
            wake_trap      <= h_trap;
            wake_nohandler <= h_nh;
          end
        end
        S_PEND: begin
          if (s_wake) begin
            st             <= S_RUN;
            wake_trap      <= s_trap;
            wake_nohandler <= s_nh;
          end else if (cnt == '0) begin
            st <= S_SLEEP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (s_wake) begin
            st             <= S_RUN;
            wake_trap      <= s_trap;
            wake_nohandler <= s_nh;
            cap_pend       <= s_irq;
          end
        end
      endcase
    end
  end

  always_comb begin
    case (st)
      S_HALT:  en_d = 5'b11000;
      S_SLEEP: en_d = 5'b00000;
      default: en_d = 5'b11111;
    endcase
  end

  always_latch begin
    if (!rst_n)    ce = 5'b11111;
    else if (!clk) ce = en_d;
  end

  assign {itc_ce, per_ce, auto_ce, ram_ce, cpu_ce} = ce;
  assign {itc_gclk, per_gclk, auto_gclk, ram_gclk, cpu_gclk} = ce & {5{clk}};
  assign switch_ok = (st == S_SLEEP);

  logic [CW:0] pend_age;
  logic [4:0]  ce_at_rise;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_age   <= '0;
      ce_at_rise <= 5'b11111;
    end else begin
      pend_age   <= (st == S_PEND) ? pend_age + 1'b1 : '0;
      ce_at_rise <= ce;
    end
  end

  a_r3_stop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PEND) |-> (pend_age <= (CW+1)'(STOP_CYC - 2)));

  a_r2_halt_domains: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ce && itc_ce) |-> (per_ce && !ram_ce && !auto_ce));

  a_r3_sleep_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !itc_ce |-> (ce == 5'b00000));

  a_r8_switch_sleep_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_sel) |-> $past(switch_ok));

  a_r6_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_trap && wake_nohandler));

  a_r6_nohandler_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wake_nohandler |-> $past(int_mask));

  a_r7_cap_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
    itc_cap |-> itc_ce);

  a_r10_glitch_free: assert property (@(negedge clk) disable iff (!rst_n)
    ce == ce_at_rise);

endmodule

// File: tb/standby_clkctl_test.sv
module standby_clkctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_req = 1'b0, sleep_req = 1'b0, nmi_n = 1'b1;
  logic [3:0] irq_lines = '0;
  logic       rtc_irq = 1'b0, dbg_break = 1'b0, int_mask = 1'b0;
  logic       wen_wr = 1'b0, wen_din = 1'b0, src_wr = 1'b0;
  logic [1:0] src_nxt = 2'd0;
  logic       cpu_ce, ram_ce, auto_ce, per_ce, itc_ce;
  logic       cpu_gclk, ram_gclk, auto_gclk, per_gclk, itc_gclk;
  logic       switch_ok, wake_en, wake_trap, wake_nohandler, itc_cap;
  logic [1:0] src_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  standby_clkctl #(.NIRQ(4), .STOP_CYC(8)) uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
    .nmi_n(nmi_n), .irq_lines(irq_lines), .rtc_irq(rtc_irq),
    .dbg_break(dbg_break), .int_mask(int_mask), .wen_wr(wen_wr),
    .wen_din(wen_din), .src_wr(src_wr), .src_nxt(src_nxt),
    .cpu_ce(cpu_ce), .ram_ce(ram_ce), .auto_ce(auto_ce), .per_ce(per_ce),
    .itc_ce(itc_ce), .cpu_gclk(cpu_gclk), .ram_gclk(ram_gclk),
    .auto_gclk(auto_gclk), .per_gclk(per_gclk), .itc_gclk(itc_gclk),
    .switch_ok(switch_ok), .src_sel(src_sel), .wake_en(wake_en),
    .wake_trap(wake_trap), .wake_nohandler(wake_nohandler), .itc_cap(itc_cap)
  );

  wire [4:0] ces = {itc_ce, per_ce, auto_ce, ram_ce, cpu_ce};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; halt_req = 0; sleep_req = 0; nmi_n = 1; irq_lines = '0;
    rtc_irq = 0; dbg_break = 0; int_mask = 0; wen_wr = 0; src_wr = 0;
    edges(2);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic enter_halt();
    halt_req = 1'b1; edges(1); halt_req = 1'b0;
  endtask

  task automatic enter_sleep();
    sleep_req = 1'b1; edges(1); sleep_req = 1'b0; edges(7);
  endtask

  task automatic set_wen(input logic v);
    wen_din = v; wen_wr = 1'b1; edges(1); wen_wr = 1'b0;
  endtask

  task automatic drive_src(input logic [1:0] s, input logic v);
    case (s)
      2'd0: nmi_n = ~v;
      2'd1: irq_lines = v ? 4'b0100 : 4'b0000;
      2'd2: rtc_irq = v;
      default: dbg_break = v;
    endcase
  endtask

  // [7] sleep, [6:5] source (0 nmi,1 irq,2 rtc,3 dbg), [4] mask, [3] wake_en,
  // [2] wake expected, [1] trap expected, [0] no-handler expected
  localparam int NV = 11;
  localparam logic [7:0] VEC [NV] = '{
    8'b0_00_1_0_110, 8'b0_01_0_0_110, 8'b0_01_1_0_101, 8'b0_10_0_0_110,
    8'b0_11_0_0_100, 8'b1_00_1_0_110, 8'b1_01_0_0_000, 8'b1_01_0_1_110,
    8'b1_01_1_1_101, 8'b1_10_1_0_101, 8'b1_11_0_1_000
  };

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 enables", 8'(ces), 8'h1f);
    chk("R1 wake_en/src_sel/switch_ok", {3'b0, wake_en, src_sel, switch_ok, 1'b0}, 8'h00);
    chk("R1 pulses", {5'b0, wake_trap, wake_nohandler, itc_cap}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] v;
      v = VEC[i];
      do_reset();
      int_mask = v[4];
      if (v[3]) set_wen(1'b1);
      if (v[7]) enter_sleep(); else enter_halt();
      chk(v[7] ? "R5 entered sleep" : "R4 entered halt", 8'(cpu_ce), 8'h0);
      drive_src(v[6:5], 1'b1);
      edges(2);
      chk(v[7] ? "R5 still off after 2 edges" : "R4 still off after 2 edges", 8'(cpu_ce), 8'h0);
      edges(1);
      chk(v[7] ? "R5 wake" : "R4 wake", 8'(cpu_ce), 8'(v[2]));
      chk("R6 trap/nohandler", {6'b0, wake_trap, wake_nohandler}, {6'b0, v[1], v[0]});
      edges(1);
      chk("R7 itc_cap", 8'(itc_cap),
          8'(v[7] & v[2] & (v[6:5] == 2'd1 || v[6:5] == 2'd2)));
      drive_src(v[6:5], 1'b0);
      edges(3);
    end

    // R2 and R10: halt domains and glitch-free gating
    do_reset();
    halt_req = 1'b1;
    @(posedge clk); #1;
    chk("R10 enable held during high phase", {6'b0, cpu_ce, cpu_gclk}, 8'h03);
    @(negedge clk); #1;
    halt_req = 1'b0;
    chk("R2 halt domains", 8'(ces), 8'h18);
    @(posedge clk); #1;
    chk("R10 gated clocks in halt", {6'b0, cpu_gclk, per_gclk}, 8'h01);

    // R3 stop delay
    do_reset();
    sleep_req = 1'b1; edges(1); sleep_req = 1'b0; edges(6);
    chk("R3 on after 7 edges", 8'(ces), 8'h1f);
    edges(1);
    chk("R3 off after 8 edges", 8'(ces), 8'h00);
    chk("R8 switch_ok asleep", 8'(switch_ok), 8'h1);

    // R8 switch accepted in sleep, ignored in run and halt
    src_nxt = 2'd2; src_wr = 1'b1; edges(1); src_wr = 1'b0;
    chk("R8 switch in sleep", 8'(src_sel), 8'h2);
    nmi_n = 1'b0; edges(3); nmi_n = 1'b1; edges(3);
    chk("R8 switch_ok low in run", 8'(switch_ok), 8'h0);
    src_nxt = 2'd1; src_wr = 1'b1; edges(1); src_wr = 1'b0;
    chk("R8 switch ignored in run", 8'(src_sel), 8'h2);
    enter_halt();
    src_nxt = 2'd3; src_wr = 1'b1; edges(1); src_wr = 1'b0;
    chk("R8 switch ignored in halt", 8'(src_sel), 8'h2);

    // R3 sleep wins over halt
    do_reset();
    halt_req = 1'b1; sleep_req = 1'b1; edges(1); halt_req = 1'b0; sleep_req = 1'b0;
    chk("R3 sleep priority pending", 8'(ces), 8'h1f);
    edges(7);
    chk("R3 sleep priority asleep", 8'(ces), 8'h00);

    // R9 sleep request ignored while halted
    do_reset();
    enter_halt();
    sleep_req = 1'b1; edges(9); sleep_req = 1'b0;
    chk("R9 sleep_req ignored in halt", 8'(ces), 8'h18);

    // R9 NMI held low wakes only once
    do_reset();
    enter_halt();
    nmi_n = 1'b0; edges(3);
    chk("R9 nmi fall wakes", 8'(cpu_ce), 8'h1);
    enter_halt(); edges(5);
    chk("R9 nmi held low no rewake", 8'(ces), 8'h18);
    nmi_n = 1'b1; edges(2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule